// File: doc/BRIEF.md
# Nine-Bit Address-Wake Serial Receiver

This block receives asynchronous serial characters from a multidrop differential bus. Each character holds nine data bits. The ninth bit is set only when the character is a station address. The line runs at a nominal 500 kbaud. The receiver is clocked by the system clock and advances only on a clock-enable pulse supplied at sixteen times the bit rate. Each bit is sampled three times around its centre and resolved by majority vote.

A mode input sets how characters are filtered. In wake mode the receiver stays quiet on the data traffic of other stations and reports only characters whose ninth bit is set. This lets the host check each address cheaply. Once the host sees its own address it switches to normal mode, and every following character is delivered whatever its ninth bit. The receiver reads the mode at the start bit of each character, so a switch never splits a character. A stop bit found low is reported as a framing error, and that character is dropped.

Top module: `nbw_rx`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_addr` is 0, `rx_valid` is 0 and `rx_frame_err` is 0.
- R2: A frame is a low start bit, then nine data bits sent least significant bit first with the address bit last, then a high stop bit, each bit lasting 16 enable pulses. A delivered character puts data bits 0..7 on `rx_data[7:0]` and the ninth bit on `rx_addr`.
- R3: In wake mode (`normal_mode` = 0), a character whose ninth bit is 0 produces no `rx_valid` pulse and leaves `rx_data` and `rx_addr` unchanged.
- R4: In wake mode, every character whose ninth bit is 1 produces one `rx_valid` pulse, with `rx_addr` = 1.
- R5: In normal mode (`normal_mode` = 1), every correctly framed character produces one `rx_valid` pulse, whatever its ninth bit.
- R6: Each bit value is the majority of the line samples taken at enable pulses 7, 8 and 9 of the bit. A single-pulse glitch within that window does not change the received value.
- R7: A low pulse that has returned high by the middle of the start bit is rejected. It produces no `rx_valid` and no `rx_frame_err`.
- R8: A stop bit sampled low gives exactly one single-cycle `rx_frame_err` pulse and no `rx_valid`. The receiver then waits for the line to go high before it accepts a new start bit.
- R9: The mode used for a character is the `normal_mode` value when its start bit is detected. A change during the character takes effect only from the next start bit.
- R10: `rx_valid` and `rx_frame_err` are single-cycle pulses and are never high together.
- R11: Reception advances only on `tick_16x` pulses, so the results are the same for any spacing of the enable pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Clock enable at 16 times the bit rate |
| rx_serial | input | 1 | Serial line, idle high |
| normal_mode | input | 1 | 1 delivers every character; 0 delivers only address characters |
| rx_data | output | 8 | Low eight data bits of the last delivered character |
| rx_addr | output | 1 | Ninth bit of the last delivered character |
| rx_valid | output | 1 | One-cycle pulse when a character is delivered |
| rx_frame_err | output | 1 | One-cycle pulse when a stop bit is sampled low |

## Verification
The assertions assume that `normal_mode` is held steady around each detected start bit. They also assume that characters are at least one stop bit apart, so a delivery pulse is never followed by another in the next cycle. The stimulus changes the mode only while the line is idle, or well inside the data bits in the cases that test mid-character changes. Every line transition is aligned to an enable pulse, and every frame ends with a full stop bit and a short idle gap. Glitch and short-pulse cases stay within the three-sample window and the half-bit start qualification that the requirements define.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_BREAK
   } rx_state_e;
endpackage

// File: rtl/nbw_sync.sv
module nbw_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nbw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RESET_VAL;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= RESET_VAL;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/nbw_bit_engine.sv
module nbw_bit_engine
   import nbw_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int CHAR_W = 9,
   parameter bit VOTE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   output logic              frame_start,
   output logic              char_done,
   output logic [CHAR_W-1:0] char_word,
   output logic              stop_ok
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0] MID   = CNT_W'(OVS / 2);
   localparam logic [CNT_W-1:0] S_A   = CNT_W'(OVS / 2 - 2);
   localparam logic [CNT_W-1:0] S_B   = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] TOP_B = BIT_W'(CHAR_W - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [1:0]        early;
   logic [BIT_W-1:0]  bidx;
   logic [CHAR_W-1:0] shreg;
   logic              vote_bit;
   logic              at_mid;
   logic              at_last;

   if (VOTE) begin : g_vote
      assign vote_bit = (early[0] & early[1]) | (early[0] & line) | (early[1] & line);
   end else begin : g_center
      assign vote_bit = line;
   end

   assign at_mid  = (cnt == MID);
   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= RX_IDLE;
         cnt         <= '0;
         early       <= 2'b11;
         bidx        <= '0;
         shreg       <= '0;
         frame_start <= 1'b0;
         char_done   <= 1'b0;
         char_word   <= '0;
         stop_ok     <= 1'b1;
      end else begin
         frame_start <= 1'b0;
         char_done   <= 1'b0;
         if (tick) begin
            if (cnt == S_A) early[0] <= line;
            if (cnt == S_B) early[1] <= line;
            unique case (state)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!line) begin
                     state       <= RX_START;
                     cnt         <= CNT_W'(1);
                     frame_start <= 1'b1;
                  end
               end
               RX_START: begin
                  cnt <= at_last ? '0 : cnt + 1'b1;
                  if (at_mid && vote_bit) begin
                     state <= RX_IDLE;
                     cnt   <= '0;
                  end else if (at_last) begin
                     state <= RX_DATA;
                     bidx  <= '0;
                  end
               end
               RX_DATA: begin
                  cnt <= at_last ? '0 : cnt + 1'b1;
                  if (at_mid) shreg <= {vote_bit, shreg[CHAR_W-1:1]};
                  if (at_last) begin
                     if (bidx == TOP_B) state <= RX_STOP;
                     else               bidx  <= bidx + 1'b1;
                  end
               end
               RX_STOP: begin
                  cnt <= cnt + 1'b1;
                  if (at_mid) begin
                     char_done <= 1'b1;
                     char_word <= shreg;
                     stop_ok   <= vote_bit;
                     state     <= vote_bit ? RX_IDLE : RX_BREAK;
                     cnt       <= '0;
                  end
               end
               RX_BREAK: begin
                  cnt <= '0;
                  if (line) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R8: a bad stop bit parks the engine until the line returns high
   a_r8_break_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && !stop_ok) |-> (state == RX_BREAK));

   // R7: a start bit that is high again by mid-bit is dropped
   a_r7_false_start: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state == RX_START && at_mid && vote_bit) |=> (state == RX_IDLE));

   // R11: no advance without an enable pulse
   a_r11_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (!char_done && !frame_start));
endmodule

// File: rtl/nbw_wake_filter.sv
module nbw_wake_filter #(
   parameter int CHAR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              normal_mode,
   input  logic              frame_start,
   input  logic              char_done,
   input  logic [CHAR_W-1:0] char_word,
   input  logic              stop_ok,
   output logic [CHAR_W-2:0] data_o,
   output logic              addr_o,
   output logic              valid_o,
   output logic              ferr_o
);
   logic mode_lat;
   logic accept;

   assign accept = char_done && stop_ok && (mode_lat || char_word[CHAR_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_lat <= 1'b0;
         data_o   <= '0;
         addr_o   <= 1'b0;
         valid_o  <= 1'b0;
         ferr_o   <= 1'b0;
      end else begin
         if (frame_start) mode_lat <= normal_mode;
         valid_o <= accept;
         ferr_o  <= char_done && !stop_ok;
         if (accept) begin
            data_o <= char_word[CHAR_W-2:0];
            addr_o <= char_word[CHAR_W-1];
         end
      end
   end

   // R3: in wake mode only address characters come out
   a_r3_wake_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !mode_lat) |-> addr_o);

   // R9: mode is sampled only at a start bit
   a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(mode_lat));

   // R10: pulses never overlap
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && ferr_o));

   // R10: valid lasts one cycle
   a_r10_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
endmodule

// File: rtl/nbw_rx.sv
module nbw_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_16x,
   input  logic              rx_serial,
   input  logic              normal_mode,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_addr,
   output logic              rx_valid,
   output logic              rx_frame_err
);
   localparam int CHAR_W = DATA_W + 1;

   if (OVERSAMPLE < 8 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_ovs
      $error("nbw_rx: OVERSAMPLE must be a power of two, at least 8");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("nbw_rx: DATA_W must be positive");
   end

   logic              line_s;
   logic              frame_start;
   logic              char_done;
   logic [CHAR_W-1:0] char_word;
   logic              stop_ok;

   nbw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_serial),
      .q     (line_s)
   );

   nbw_bit_engine #(.OVS(OVERSAMPLE), .CHAR_W(CHAR_W), .VOTE(MAJORITY)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_16x),
      .line        (line_s),
      .frame_start (frame_start),
      .char_done   (char_done),
      .char_word   (char_word),
      .stop_ok     (stop_ok)
   );

   nbw_wake_filter #(.CHAR_W(CHAR_W)) u_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .normal_mode (normal_mode),
      .frame_start (frame_start),
      .char_done   (char_done),
      .char_word   (char_word),
      .stop_ok     (stop_ok),
      .data_o      (rx_data),
      .addr_o      (rx_addr),
      .valid_o     (rx_valid),
      .ferr_o      (rx_frame_err)
   );
endmodule

// File: tb/tb_nbw_rx.sv
module tb_nbw_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rx = 1'b1;
   logic       nmode = 1'b0;
   logic [7:0] rx_data;
   logic       rx_addr;
   logic       rx_valid;
   logic       rx_frame_err;

   int checks = 0;
   int fails  = 0;
   int div    = 1;
   int dcnt   = 0;
   int vcnt   = 0;
   int ecnt   = 0;
   logic [7:0] seen_data;
   logic       seen_addr;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   nbw_rx dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_16x     (tick),
      .rx_serial    (rx),
      .normal_mode  (nmode),
      .rx_data      (rx_data),
      .rx_addr      (rx_addr),
      .rx_valid     (rx_valid),
      .rx_frame_err (rx_frame_err)
   );

   always @(posedge clk) begin
      if (dcnt >= div - 1) begin
         dcnt <= 0;
         tick <= 1'b1;
      end else begin
         dcnt <= dcnt + 1;
         tick <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            vcnt <= vcnt + 1;
            seen_data <= rx_data;
            seen_addr <= rx_addr;
         end
         if (rx_frame_err) ecnt <= ecnt + 1;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_tick();
      do @(negedge clk); while (!tick);
   endtask

   task automatic drive(input logic v, input int n);
      rx = v;
      for (int k = 0; k < n; k++) wait_tick();
   endtask

   // frame: start, nine bits LSB first, stop; optional glitch and mode switch
   task automatic send(input logic [8:0] w, input logic bad_stop,
                       input int gbit, input int goff,
                       input int chg_bit, input logic chg_mode);
      drive(1'b0, 16);
      for (int i = 0; i < 9; i++) begin
         if (i == chg_bit) nmode = chg_mode;
         for (int j = 0; j < 16; j++) begin
            rx = w[i] ^ (i == gbit && j == goff);
            wait_tick();
         end
      end
      drive(~bad_stop, 16);
      drive(1'b1, 6);
   endtask

   task automatic frame_check(input string tag, input logic [8:0] w, input logic bad_stop,
                              input int gbit, input int chg_bit, input logic chg_mode);
      logic mode0;
      int   ev;
      int   pv;
      logic [7:0] pd;
      logic pa;
      mode0 = nmode;
      pv = vcnt;
      pd = seen_data;
      pa = seen_addr;
      ecnt = 0;
      send(w, bad_stop, gbit, 6, chg_bit, chg_mode);
      ev = (!bad_stop && (mode0 || w[8])) ? 1 : 0;
      check(tag, vcnt - pv, ev);
      check(tag, ecnt, bad_stop ? 1 : 0);
      if (ev == 1) begin
         check(tag, int'(seen_data), int'(w[7:0]));
         check(tag, int'(seen_addr), int'(w[8]));
      end else if (vcnt == pv) begin
         check(tag, int'(rx_data), int'(pd));
         check(tag, int'(rx_addr), int'(pa));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 data", int'(rx_data), 0);
      check("R1 addr", int'(rx_addr), 0);
      check("R1 valid", int'(rx_valid), 0);
      check("R1 ferr", int'(rx_frame_err), 0);
      rst_n = 1'b1;
      drive(1'b1, 20);

      // R3 R4: wake mode sweep, ninth bit follows value bit 0
      nmode = 1'b0;
      for (int v = 0; v < 256; v++)
         frame_check("R3/R4 wake sweep", {v[0], v[7:0]}, 1'b0, -1, -1, 1'b0);

      // R2 R5: normal mode sweep, both ninth-bit values
      nmode = 1'b1;
      for (int v = 0; v < 128; v++)
         frame_check("R2/R5 normal sweep", {v[1] ^ v[6], v[7:0] ^ 8'hA5}, 1'b0, -1, -1, 1'b0);

      // R6: one-tick glitch inside the voting window of several bits
      for (int b = 0; b < 9; b++)
         frame_check("R6 glitch", 9'h15A, 1'b0, b, -1, 1'b0);

      // R7: short low pulse rejected
      vcnt = 0;
      ecnt = 0;
      drive(1'b0, 5);
      drive(1'b1, 40);
      check("R7 no valid", vcnt, 0);
      check("R7 no ferr", ecnt, 0);
      frame_check("R7 after", 9'h0C3, 1'b0, -1, -1, 1'b0);

      // R8: framing error, then recovery
      frame_check("R8 bad stop", 9'h1FF, 1'b1, -1, -1, 1'b0);
      frame_check("R8 recover", 9'h03C, 1'b0, -1, -1, 1'b0);

      // R9: mode changes mid-character apply from the next start
      nmode = 1'b0;
      frame_check("R9 wake->normal mid", 9'h055, 1'b0, -1, 3, 1'b1);
      frame_check("R9 now normal", 9'h066, 1'b0, -1, -1, 1'b0);
      frame_check("R9 normal->wake mid", 9'h077, 1'b0, -1, 4, 1'b0);
      frame_check("R9 now wake", 9'h088, 1'b0, -1, -1, 1'b0);

      // R11: sparse enable pulses
      div = 3;
      drive(1'b1, 4);
      frame_check("R11 div3 addr", 9'h1A7, 1'b0, -1, -1, 1'b0);
      frame_check("R11 div3 data", 9'h0A7, 1'b0, -1, -1, 1'b0);
      nmode = 1'b1;
      frame_check("R11 div3 normal", 9'h0E1, 1'b0, -1, -1, 1'b0);
      frame_check("R11 div3 bad stop", 9'h0E1, 1'b1, -1, -1, 1'b0);
      // R10: pulses counted one per frame throughout via frame_check deltas
      frame_check("R10 div3 single", 9'h101, 1'b0, -1, -1, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule